// File: doc/BRIEF.md
# Splittable 64-bit Up-Counting Timer

This peripheral holds a 64-bit up-counter that software can also run as two independent 32-bit up-counters, a lower half and an upper half. A global control word selects the arrangement and releases each half from reset. An enable control word gives each half a two-bit run mode: stopped, one-shot or periodic. Each half has its own period register and its own counter register, and software may overwrite either counter at any time. When a running count equals its period, the half raises a one-cycle interrupt pulse. In periodic mode the half then restarts from zero. In one-shot mode it keeps its count and returns its own run mode to stopped.

Access goes through a simple word-addressed register bus. Writes take effect at the clock edge on which `bus_wr` is high. Reads are combinational from `bus_addr`. The address map is: 0 global control, 1 enable control, 2 lower counter, 3 upper counter, 4 lower period, 5 upper period. Addresses 6 and 7 read as zero and ignore writes.

Top module: `split_timer64`

## Requirements
- R1: After reset all six registers read zero and both interrupt outputs are low.
- R2: Field layout and readback:
  - Global control: bits 1:0 are the lower and upper release bits; bits 3:2 are the arrangement field.
  - Enable control: bits 7:6 hold the lower run mode; bits 23:22 hold the upper run mode.
  - Every other bit of these two registers reads zero.
  - Addresses 6 and 7 read zero.
- R3: With the arrangement field at 1 (split), each released half whose run mode is 1 or 2 adds one to its counter on every clock, independently of the other half.
- R4: Periodic mode (run mode 2): when a running count equals its period, the next edge pulses that half's interrupt and loads zero. A period of P therefore gives one pulse every P+1 clocks.
- R5: One-shot mode (run mode 1): when a running count equals its period, the next edge pulses the interrupt once, holds the count and sets that half's run mode field to 0.
- R6: Run mode 0 (stopped) and run mode 3 (reserved) freeze the counter and produce no interrupt.
- R7: A half whose release bit is 0 holds its counter at zero, ignores writes to its counter and ignores its run mode.
- R8: Arrangement values 0, 2 and 3 select the joined 64-bit mode:
  - The counter is {upper, lower}, and the lower half carries into the upper half.
  - It is compared with {upper period, lower period}.
  - It is governed by the lower run mode, and it counts only when both release bits are 1.
  - It interrupts on `irq_lo` only. The upper run mode is ignored and `irq_hi` stays low.
- R9: A bus write to a counter register takes priority over counting and over a periodic restart on the same edge. A bus write to the enable control register takes priority over the one-shot self-clear.
- R10: Writing 0 to the enable control register stops both halves, and both counters keep their values.
- R11: Each interrupt is a one-cycle pulse whenever the period is at least 1. A periodic half with period 0 pulses on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_addr | input | AW (3) | Word address of the register |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Combinational read data for `bus_addr` |
| irq_lo | output | 1 | Lower-half interrupt pulse; also the joined-mode interrupt |
| irq_hi | output | 1 | Upper-half interrupt pulse |

## Verification
The assertions check the following on every clock:
- the single-step increment of a running half;
- the zero-holding of a half in reset, and the silence of its interrupt;
- the freeze of a stopped half;
- the restart to zero after a periodic match;
- the self-clear of a one-shot half and the holding of its count;
- the silence of `irq_hi` in joined mode.

Other properties need whole scenarios, and only the bench shows them:
- the pulse spacing over many periods;
- the carry from the lower word into the upper word at a 64-bit match;
- the register field positions;
- the priority of a counter write that lands while the half is counting.

// File: rtl/split_timer_pkg.sv
package split_timer_pkg;

  typedef enum logic [1:0] {
    EN_OFF  = 2'd0,
    EN_ONCE = 2'd1,
    EN_LOOP = 2'd2,
    EN_RSV  = 2'd3
  } en_mode_e;

  typedef enum logic [1:0] {
    TM_WIDE  = 2'd0,
    TM_SPLIT = 2'd1,
    TM_WDOG  = 2'd2,
    TM_CHAIN = 2'd3
  } tm_mode_e;

  localparam int TM_LSB    = 2;
  localparam int LO_EN_LSB = 6;
  localparam int HI_EN_LSB = 22;

  localparam int A_GCTL   = 0;
  localparam int A_ECTL   = 1;
  localparam int A_CNT_LO = 2;
  localparam int A_CNT_HI = 3;
  localparam int A_PRD_LO = 4;
  localparam int A_PRD_HI = 5;

  function automatic logic en_runs(input logic [1:0] m);
    return (m == EN_ONCE) || (m == EN_LOOP);
  endfunction

endpackage

// File: rtl/st_regs.sv
module st_regs
  import split_timer_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [1:0]    once_done,
  output logic [1:0]    rel,
  output tm_mode_e      tmode,
  output logic [1:0]    en_lo,
  output logic [1:0]    en_hi,
  output logic [DW-1:0] prd_lo,
  output logic [DW-1:0] prd_hi
);

  logic wr_gctl, wr_ectl, wr_plo, wr_phi;

  assign wr_gctl = wr && (addr == AW'(A_GCTL));
  assign wr_ectl = wr && (addr == AW'(A_ECTL));
  assign wr_plo  = wr && (addr == AW'(A_PRD_LO));
  assign wr_phi  = wr && (addr == AW'(A_PRD_HI));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel    <= 2'b00;
      tmode  <= TM_WIDE;
      en_lo  <= EN_OFF;
      en_hi  <= EN_OFF;
      prd_lo <= '0;
      prd_hi <= '0;
    end else begin
      if (wr_gctl) begin
        rel   <= wdata[1:0];
        tmode <= tm_mode_e'(wdata[TM_LSB +: 2]);
      end
      if (wr_ectl) begin
        en_lo <= wdata[LO_EN_LSB +: 2];
        en_hi <= wdata[HI_EN_LSB +: 2];
      end else begin
        if (once_done[0]) en_lo <= EN_OFF;
        if (once_done[1]) en_hi <= EN_OFF;
      end
      if (wr_plo) prd_lo <= wdata;
      if (wr_phi) prd_hi <= wdata;
    end
  end

endmodule

// File: rtl/st_half_counter.sv
module st_half_counter #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          restart,
  input  logic          step,
  output logic [DW-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (hold)    cnt <= '0;
    else if (load)    cnt <= load_val;
    else if (restart) cnt <= '0;
    else if (step)    cnt <= cnt + DW'(1);
  end

endmodule

// File: rtl/st_ctrl.sv
module st_ctrl
  import split_timer_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          split,
  input  logic [1:0]    rel,
  input  logic [1:0]    en_lo,
  input  logic [1:0]    en_hi,
  input  logic [DW-1:0] cnt_lo,
  input  logic [DW-1:0] cnt_hi,
  input  logic [DW-1:0] prd_lo,
  input  logic [DW-1:0] prd_hi,
  output logic [1:0]    hold,
  output logic [1:0]    step,
  output logic [1:0]    hit,
  output logic [1:0]    restart,
  output logic [1:0]    once_done
);

  localparam int WW = 2 * DW;

  function automatic logic all_ones(input logic [DW-1:0] c);
    return &c;
  endfunction

  function automatic logic wide_match(input logic [DW-1:0] ch, input logic [DW-1:0] cl,
                                      input logic [DW-1:0] ph, input logic [DW-1:0] pl);
    logic [WW-1:0] c, p;
    c = {ch, cl};
    p = {ph, pl};
    return c == p;
  endfunction

  logic [1:0]    en_v [2];
  logic [DW-1:0] c_v  [2];
  logic [DW-1:0] p_v  [2];
  logic          act;

  assign en_v[0] = en_lo;
  assign en_v[1] = en_hi;
  assign c_v[0]  = cnt_lo;
  assign c_v[1]  = cnt_hi;
  assign p_v[0]  = prd_lo;
  assign p_v[1]  = prd_hi;

  always_comb begin
    hold      = '0;
    step      = '0;
    hit       = '0;
    restart   = '0;
    once_done = '0;
    act       = 1'b0;
    if (split) begin
      for (int i = 0; i < 2; i++) begin
        hold[i]      = !rel[i];
        act          = !hold[i] && en_runs(en_v[i]);
        hit[i]       = act && (c_v[i] == p_v[i]);
        step[i]      = act && !hit[i];
        restart[i]   = hit[i] && (en_v[i] == EN_LOOP);
        once_done[i] = hit[i] && (en_v[i] == EN_ONCE);
      end
    end else begin
      hold         = {2{rel != 2'b11}};
      act          = !hold[0] && en_runs(en_lo);
      hit[0]       = act && wide_match(cnt_hi, cnt_lo, prd_hi, prd_lo);
      step[0]      = act && !hit[0];
      step[1]      = step[0] && all_ones(cnt_lo);
      restart      = {2{hit[0] && (en_lo == EN_LOOP)}};
      once_done[0] = hit[0] && (en_lo == EN_ONCE);
    end
  end

endmodule

// File: rtl/split_timer64.sv
module split_timer64
  import split_timer_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_lo,
  output logic          irq_hi
);

  logic [1:0]    rel;
  tm_mode_e      tmode;
  logic [1:0]    en_lo, en_hi;
  logic [DW-1:0] prd_lo, prd_hi, cnt_lo, cnt_hi;
  logic [DW-1:0] cnt_arr [2];

  // named internal events, also observed by the checker
  logic       split_w;
  logic [1:0] hold_w, step_w, hit_w, restart_w, once_w, load_w;
  logic [1:0] irq_q;

  assign split_w   = (tmode == TM_SPLIT);
  assign load_w[0] = bus_wr && (bus_addr == AW'(A_CNT_LO));
  assign load_w[1] = bus_wr && (bus_addr == AW'(A_CNT_HI));

  st_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .once_done(once_w), .rel(rel), .tmode(tmode), .en_lo(en_lo), .en_hi(en_hi),
    .prd_lo(prd_lo), .prd_hi(prd_hi)
  );

  st_ctrl #(.DW(DW)) u_ctrl (
    .split(split_w), .rel(rel), .en_lo(en_lo), .en_hi(en_hi),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .prd_lo(prd_lo), .prd_hi(prd_hi),
    .hold(hold_w), .step(step_w), .hit(hit_w), .restart(restart_w), .once_done(once_w)
  );

  for (genvar g = 0; g < 2; g++) begin : g_half
    st_half_counter #(.DW(DW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .hold(hold_w[g]), .load(load_w[g]),
      .load_val(bus_wdata), .restart(restart_w[g]), .step(step_w[g]),
      .cnt(cnt_arr[g])
    );
  end

  assign cnt_lo = cnt_arr[0];
  assign cnt_hi = cnt_arr[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 2'b00;
    else        irq_q <= hit_w;
  end

  assign irq_lo = irq_q[0];
  assign irq_hi = irq_q[1];

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(A_GCTL): begin
        bus_rdata[1:0]          = rel;
        bus_rdata[TM_LSB +: 2]  = tmode;
      end
      AW'(A_ECTL): begin
        bus_rdata[LO_EN_LSB +: 2] = en_lo;
        bus_rdata[HI_EN_LSB +: 2] = en_hi;
      end
      AW'(A_CNT_LO): bus_rdata = cnt_lo;
      AW'(A_CNT_HI): bus_rdata = cnt_hi;
      AW'(A_PRD_LO): bus_rdata = prd_lo;
      AW'(A_PRD_HI): bus_rdata = prd_hi;
      default:       bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/st_checker.sv
module st_checker
  import split_timer_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr,
  input logic [AW-1:0] addr,
  input logic          split,
  input logic          hold_lo,
  input logic          step_lo,
  input logic          hit_lo,
  input logic [1:0]    en_lo,
  input logic [DW-1:0] cnt_lo,
  input logic          irq_lo,
  input logic          irq_hi
);

  logic wr_cnt_lo, wr_ectl;
  assign wr_cnt_lo = wr && (addr == AW'(A_CNT_LO));
  assign wr_ectl   = wr && (addr == AW'(A_ECTL));

  // R3: a running half advances by exactly one
  p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_lo && !wr_cnt_lo) |=> (cnt_lo == $past(cnt_lo) + DW'(1)));

  // R4: periodic match restarts from zero
  p_loop_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_lo && en_lo == EN_LOOP && !wr_cnt_lo) |=> (cnt_lo == '0));

  // R5: one-shot match clears its run mode
  p_once_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_lo && en_lo == EN_ONCE && !wr_ectl) |=> (en_lo == EN_OFF));

  // R5: one-shot match keeps the count
  p_once_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_lo && en_lo == EN_ONCE && !wr_cnt_lo) |=> $stable(cnt_lo));

  // R6: stopped or reserved mode freezes the count
  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_lo && !en_runs(en_lo) && !wr_cnt_lo) |=> $stable(cnt_lo));

  // R7: a half in reset reads zero
  p_hold_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_lo |=> (cnt_lo == '0));

  // R7: a half in reset never interrupts
  p_hold_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_lo |=> !irq_lo);

  // R8: upper interrupt silent in joined mode
  p_wide_hi_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !split |=> !irq_hi);

endmodule

bind split_timer64 st_checker #(.DW(DW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .split(split_w),
  .hold_lo(hold_w[0]), .step_lo(step_w[0]), .hit_lo(hit_w[0]), .en_lo(en_lo),
  .cnt_lo(cnt_lo), .irq_lo(irq_lo), .irq_hi(irq_hi)
);

// File: tb/split_timer64_tb_top.sv
`timescale 1ns/1ps
module split_timer64_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_lo, irq_hi;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  split_timer64 dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  // register addresses and field positions as stated in R2
  localparam int GCTL = 0, ECTL = 1, CLO = 2, CHI = 3, PLO = 4, PHI = 5;

  typedef struct packed {
    logic        hi;
    logic [1:0]  mode;
    logic [31:0] prd;
    logic [7:0]  cycles;
    logic [7:0]  irqs;
    logic [31:0] cnt;
    logic [1:0]  en_after;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 2'd2, 32'd3, 8'd10, 8'd2, 32'd2, 2'd2},
    '{1'b0, 2'd2, 32'd0, 8'd5,  8'd5, 32'd0, 2'd2},
    '{1'b0, 2'd1, 32'd5, 8'd12, 8'd1, 32'd5, 2'd0},
    '{1'b0, 2'd1, 32'd5, 8'd4,  8'd0, 32'd4, 2'd1},
    '{1'b0, 2'd0, 32'd7, 8'd6,  8'd0, 32'd0, 2'd0},
    '{1'b0, 2'd3, 32'd2, 8'd6,  8'd0, 32'd0, 2'd3},
    '{1'b1, 2'd2, 32'd1, 8'd7,  8'd3, 32'd1, 2'd2},
    '{1'b1, 2'd1, 32'd4, 8'd9,  8'd1, 32'd4, 2'd0}
  };

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a[2:0]; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input int a, output logic [31:0] v);
    bus_addr = a[2:0];
    #1;
    v = bus_rdata;
  endtask

  initial begin : main
    logic [31:0] v, v2, a1, a2;
    int nirq, nother;
    string tag;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 6; a++) begin
      rd_reg(a, v);
      chk("R1", "register after reset", v, 0);
    end
    chk("R1", "irq_lo after reset", irq_lo, 0);
    chk("R1", "irq_hi after reset", irq_hi, 0);

    // R2: field positions and unused bits
    wr_reg(GCTL, 32'hFFFF_FFFF);
    rd_reg(GCTL, v);
    chk("R2", "global control readback", v, 32'h0000_000F);
    wr_reg(ECTL, 32'hFFFF_FFFF);
    rd_reg(ECTL, v);
    chk("R2", "enable control readback", v, 32'h00C0_00C0);
    wr_reg(7, 32'hFFFF_FFFF);
    rd_reg(7, v);
    chk("R2", "unmapped address", v, 0);
    wr_reg(ECTL, 0);

    // vector table: split mode, one half at a time
    foreach (VECS[i]) begin
      wr_reg(ECTL, 0);
      wr_reg(GCTL, 32'h7);
      wr_reg(VECS[i].hi ? PHI : PLO, VECS[i].prd);
      wr_reg(VECS[i].hi ? CHI : CLO, 0);
      wr_reg(ECTL, {30'd0, VECS[i].mode} << (VECS[i].hi ? 22 : 6));
      nirq = 0; nother = 0;
      for (int k = 0; k < int'(VECS[i].cycles); k++) begin
        @(negedge clk);
        if (VECS[i].hi ? irq_hi : irq_lo) nirq++;
        if (VECS[i].hi ? irq_lo : irq_hi) nother++;
      end
      tag = (VECS[i].mode == 2'd2) ? "R4" : (VECS[i].mode == 2'd1) ? "R5" : "R6";
      chk(tag, $sformatf("vec %0d pulse count", i), nirq, VECS[i].irqs);
      rd_reg(VECS[i].hi ? CHI : CLO, v);
      chk(tag, $sformatf("vec %0d count", i), v, VECS[i].cnt);
      rd_reg(ECTL, v);
      chk(tag, $sformatf("vec %0d run mode", i), v[VECS[i].hi ? 22 : 6 +: 2], VECS[i].en_after);
      chk("R3", $sformatf("vec %0d other half quiet", i), nother, 0);
    end

    // R7: lower half held in reset
    wr_reg(ECTL, 0);
    wr_reg(GCTL, 32'h6);
    wr_reg(CLO, 32'd9);
    rd_reg(CLO, v);
    chk("R7", "counter write ignored in reset", v, 0);
    wr_reg(PLO, 2);
    wr_reg(ECTL, 2 << 6);
    nirq = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (irq_lo) nirq++;
    end
    chk("R7", "no pulse in reset", nirq, 0);
    rd_reg(CLO, v);
    chk("R7", "count stays zero", v, 0);

    // R8: joined 64-bit mode with carry, one-shot, upper mode ignored
    wr_reg(ECTL, 0);
    wr_reg(GCTL, 32'h3);
    wr_reg(CLO, 32'hFFFF_FFFE);
    wr_reg(CHI, 0);
    wr_reg(PLO, 1);
    wr_reg(PHI, 1);
    wr_reg(ECTL, (1 << 6) | (2 << 22));
    nother = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (irq_lo || irq_hi) nother++;
    end
    chk("R8", "no pulse before 64-bit match", nother, 0);
    rd_reg(CLO, v);
    rd_reg(CHI, v2);
    chk("R8", "64-bit count after carry", {v2, v}, 64'h1_0000_0001);
    @(negedge clk);
    chk("R8", "irq_lo at 64-bit match", irq_lo, 1);
    chk("R8", "irq_hi silent in joined mode", irq_hi, 0);
    @(negedge clk);
    chk("R11", "irq_lo single cycle", irq_lo, 0);
    rd_reg(ECTL, v);
    chk("R5", "joined one-shot clears lower mode only", v, 32'h0080_0000);
    rd_reg(CLO, v);
    rd_reg(CHI, v2);
    chk("R5", "joined one-shot holds count", {v2, v}, 64'h1_0000_0001);

    // R9: counter write wins over counting
    wr_reg(ECTL, 0);
    wr_reg(GCTL, 32'h7);
    wr_reg(PLO, 100);
    wr_reg(CLO, 0);
    wr_reg(ECTL, 2 << 6);
    repeat (3) @(negedge clk);
    wr_reg(CLO, 50);
    rd_reg(CLO, v);
    chk("R9", "loaded value", v, 50);
    @(negedge clk);
    rd_reg(CLO, v);
    chk("R9", "counting resumes from load", v, 51);

    // R10: writing zero stops both halves
    wr_reg(PHI, 1000);
    wr_reg(ECTL, (2 << 6) | (2 << 22));
    repeat (5) @(negedge clk);
    wr_reg(ECTL, 0);
    rd_reg(CLO, a1);
    rd_reg(CHI, a2);
    repeat (4) @(negedge clk);
    rd_reg(CLO, v);
    rd_reg(CHI, v2);
    chk("R10", "lower frozen", v, a1);
    chk("R10", "upper frozen", v2, a2);
    chk("R10", "upper had counted", (a2 != 0), 1);
    rd_reg(ECTL, v);
    chk("R10", "both modes stopped", v, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule